// File: doc/BRIEF.md
# Multi-Bus I2C Wiring Self-Test

This block runs once at bring-up to find out which of the chip's I2C line pairs are really wired. For each bus in turn it returns the bus to idle with a STOP condition. It then drives the clock and data lines directly through two complementary loopback patterns and reads each line back through an input synchronizer. A bus that passes both patterns is marked present and is returned to idle with a second STOP. A bus that fails either pattern is marked absent, and the probe moves straight on to the next bus.

Outputs are open-drain requests: a `1` on a `*_low_o` bit pulls that line low, and a `0` releases it. Inputs report the observed line level, where `1` means high. All waits are counted in units, and one unit is `UNIT_CYCLES` clock cycles. The bus count is sampled from `three_bus_i` when the start pulse is accepted.

Top module: `i2c_wire_probe`

## Requirements
- R1: A start pulse accepted while idle clears every present flag and `any_ok_o`, and releases the clock and data lines of every bus. All of this is visible in the cycle after the start edge.
- R2: `three_bus_i` is sampled at start. A 0 selects buses 0 and 1; a 1 selects buses 0, 1 and 2. A bus that is not selected keeps its flag at 0 and both of its lines released, whatever `three_bus_i` does later.
- R3: Each bus test begins with a 6-unit wait, followed by a STOP. The STOP pulls data low, releases clock 3 units later, releases data 9 units after that, and then holds for 6 units. Buses are visited in ascending index order.
- R4: Pattern one starts 6 units after the STOP ends. Clock is pulled low, data is released 3 units later, and the lines are sampled 3 units after that. The pattern passes only if clock reads low and data reads high.
- R5: Pattern two starts 3 units after a pass of pattern one. Clock is released, data is pulled low 3 units later, and the lines are sampled 3 units after that. The pattern passes only if clock reads high and data reads low.
- R6: When both patterns pass, the bus's present flag is set. Three units later the same STOP shape as in R3 runs, which leaves both lines released.
- R7: When either pattern fails, the flag stays 0 and the next bus starts at once, with no STOP. The failed bus keeps the drive it had at the failing sample: a failure of pattern one leaves clock pulled low and data released, and a failure of pattern two leaves clock released and data pulled low.
- R8: `any_ok_o` is the OR of the present flags at completion. It is held, together with the flags, until the next start.
- R9: `done_o` is a one-cycle pulse. It comes exactly 66, 36 or 45 units after start for each tested bus, for a pass, a failure of pattern one, or a failure of pattern two respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| three_bus_i | input | 1 | 1 selects three buses, 0 selects two |
| scl_in_i | input | NBUS_MAX | Observed clock line level per bus |
| sda_in_i | input | NBUS_MAX | Observed data line level per bus |
| scl_low_o | output | NBUS_MAX | Pull clock line low, per bus |
| sda_low_o | output | NBUS_MAX | Pull data line low, per bus |
| present_o | output | NBUS_MAX | Bus passed both loopback patterns |
| any_ok_o | output | 1 | At least one bus present |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach are the two distinct failure exits: a bus that passes pattern one but fails pattern two, and a mix of good and broken buses within one run. Only these exits show whether the probe leaves the right residual drive and skips the closing STOP. The bench places a line-fault model on every bus (good, clock stuck low, data stuck high, lines crossed). It sweeps every combination of fault across all three buses with both bus counts, and it flips the bus-count input just after start. From the same fault table it computes the expected flags, the residual drives and the exact completion cycle. One additional run on healthy buses records every drive change on bus 0 and compares its timing with the unit schedule.

// File: rtl/i2c_wire_probe_pkg.sv
package i2c_wire_probe_pkg;

    localparam int unsigned WAIT_MAX_UNITS = 12;
    localparam int unsigned UNITS_W        = 4;

    typedef logic [UNITS_W-1:0] units_t;

    // wait lengths in units
    localparam units_t W_LEAD      = units_t'(6);
    localparam units_t W_GAP       = units_t'(6);
    localparam units_t W_STEP      = units_t'(3);
    localparam units_t W_STOP_HOLD = units_t'(3);
    localparam units_t W_STOP_RISE = units_t'(9);
    localparam units_t W_STOP_END  = units_t'(6);

    // one-cycle line command toward the selected bus
    typedef struct packed {
        logic scl_set;
        logic scl_low;
        logic sda_set;
        logic sda_low;
    } line_cmd_t;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_LEAD,
        PS_STOP_PRE,
        PS_GAP,
        PS_P1_LOW,
        PS_P1_REL,
        PS_P2_WAIT,
        PS_P2_REL,
        PS_P2_LOW,
        PS_TAIL,
        PS_STOP_POST
    } probe_state_e;

    typedef enum logic [1:0] {
        SS_IDLE,
        SS_HOLD,
        SS_RISE,
        SS_END
    } stop_state_e;

endpackage

// File: rtl/i2c_wire_probe_timer.sv
module i2c_wire_probe_timer
    import i2c_wire_probe_pkg::*;
#(
    parameter int unsigned UNIT_CYCLES = 8,
    parameter int unsigned CNT_W       = 7
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  units_t units_i,
    output logic   expire_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d     = tm_q;
        expire_o = tm_q.run && (tm_q.cnt == '0);
        if (load_i) begin
            tm_d.run = 1'b1;
            tm_d.cnt = CNT_W'(units_i * UNIT_CYCLES) - CNT_W'(1);
        end else if (tm_q.run) begin
            if (tm_q.cnt == '0) begin
                tm_d.run = 1'b0;
            end else begin
                tm_d.cnt = tm_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

endmodule

// File: rtl/i2c_wire_probe_stop.sv
module i2c_wire_probe_stop
    import i2c_wire_probe_pkg::*;
#(
    parameter int unsigned UNIT_CYCLES = 8,
    parameter int unsigned CNT_W       = 7
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_i,
    output line_cmd_t cmd_o,
    output logic      done_o
);

    typedef struct packed {
        stop_state_e state;
    } stop_t;

    stop_t  st_d, st_q;
    logic   tmr_load;
    units_t tmr_units;
    logic   tmr_expire;

    i2c_wire_probe_timer #(
        .UNIT_CYCLES(UNIT_CYCLES),
        .CNT_W      (CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .units_i (tmr_units),
        .expire_o(tmr_expire)
    );

    always_comb begin
        st_d      = st_q;
        cmd_o     = '0;
        done_o    = 1'b0;
        tmr_load  = 1'b0;
        tmr_units = '0;
        unique case (st_q.state)
            SS_IDLE: begin
                if (go_i) begin
                    cmd_o.sda_set = 1'b1;
                    cmd_o.sda_low = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_units     = W_STOP_HOLD;
                    st_d.state    = SS_HOLD;
                end
            end
            SS_HOLD: begin
                if (tmr_expire) begin
                    cmd_o.scl_set = 1'b1;
                    cmd_o.scl_low = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_units     = W_STOP_RISE;
                    st_d.state    = SS_RISE;
                end
            end
            SS_RISE: begin
                if (tmr_expire) begin
                    cmd_o.sda_set = 1'b1;
                    cmd_o.sda_low = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_units     = W_STOP_END;
                    st_d.state    = SS_END;
                end
            end
            SS_END: begin
                if (tmr_expire) begin
                    done_o     = 1'b1;
                    st_d.state = SS_IDLE;
                end
            end
            default: st_d.state = SS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= SS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/i2c_wire_probe_lines.sv
module i2c_wire_probe_lines
    import i2c_wire_probe_pkg::*;
#(
    parameter int unsigned NBUS        = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SEL_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             release_all_i,
    input  logic [SEL_W-1:0] sel_i,
    input  line_cmd_t        cmd_i,
    input  logic [NBUS-1:0]  scl_in_i,
    input  logic [NBUS-1:0]  sda_in_i,
    output logic [NBUS-1:0]  scl_low_o,
    output logic [NBUS-1:0]  sda_low_o,
    output logic             scl_seen_o,
    output logic             sda_seen_o
);

    typedef struct packed {
        logic                   scl_low;
        logic                   sda_low;
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
    } lane_t;

    logic [NBUS-1:0] scl_synced;
    logic [NBUS-1:0] sda_synced;

    for (genvar b = 0; b < NBUS; b++) begin : g_lane
        lane_t ln_d, ln_q;
        logic  hit;

        assign hit = (sel_i == SEL_W'(b));

        always_comb begin
            ln_d          = ln_q;
            ln_d.scl_sync = (ln_q.scl_sync << 1) | SYNC_STAGES'(scl_in_i[b]);
            ln_d.sda_sync = (ln_q.sda_sync << 1) | SYNC_STAGES'(sda_in_i[b]);
            if (release_all_i) begin
                ln_d.scl_low = 1'b0;
                ln_d.sda_low = 1'b0;
            end else if (hit) begin
                if (cmd_i.scl_set) begin
                    ln_d.scl_low = cmd_i.scl_low;
                end
                if (cmd_i.sda_set) begin
                    ln_d.sda_low = cmd_i.sda_low;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ln_q.scl_low  <= 1'b0;
                ln_q.sda_low  <= 1'b0;
                ln_q.scl_sync <= '1;
                ln_q.sda_sync <= '1;
            end else begin
                ln_q <= ln_d;
            end
        end

        assign scl_low_o[b]  = ln_q.scl_low;
        assign sda_low_o[b]  = ln_q.sda_low;
        assign scl_synced[b] = ln_q.scl_sync[SYNC_STAGES-1];
        assign sda_synced[b] = ln_q.sda_sync[SYNC_STAGES-1];
    end

    assign scl_seen_o = scl_synced[sel_i];
    assign sda_seen_o = sda_synced[sel_i];

endmodule

// File: rtl/i2c_wire_probe.sv
module i2c_wire_probe
    import i2c_wire_probe_pkg::*;
#(
    parameter int unsigned NBUS_MAX    = 3,
    parameter int unsigned NBUS_FEW    = 2,
    parameter int unsigned UNIT_CYCLES = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                three_bus_i,
    input  logic [NBUS_MAX-1:0] scl_in_i,
    input  logic [NBUS_MAX-1:0] sda_in_i,
    output logic [NBUS_MAX-1:0] scl_low_o,
    output logic [NBUS_MAX-1:0] sda_low_o,
    output logic [NBUS_MAX-1:0] present_o,
    output logic                any_ok_o,
    output logic                done_o
);

    localparam int unsigned SEL_W = (NBUS_MAX > 1) ? $clog2(NBUS_MAX) : 1;
    localparam int unsigned CNT_W = $clog2(WAIT_MAX_UNITS * UNIT_CYCLES + 1);

    typedef struct packed {
        probe_state_e        state;
        logic [SEL_W-1:0]    bus;
        logic [SEL_W-1:0]    last;
        logic [NBUS_MAX-1:0] present;
        logic                any_ok;
        logic                done;
    } probe_t;

    probe_t    pr_d, pr_q;
    logic      tmr_load;
    units_t    tmr_units;
    logic      tmr_expire;
    logic      stop_go;
    logic      stop_done;
    line_cmd_t top_cmd;
    line_cmd_t stop_cmd;
    line_cmd_t line_cmd;
    logic      release_all;
    logic      scl_seen;
    logic      sda_seen;
    logic      advance;
    logic      idle_w;

    i2c_wire_probe_timer #(
        .UNIT_CYCLES(UNIT_CYCLES),
        .CNT_W      (CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .units_i (tmr_units),
        .expire_o(tmr_expire)
    );

    i2c_wire_probe_stop #(
        .UNIT_CYCLES(UNIT_CYCLES),
        .CNT_W      (CNT_W)
    ) u_stop (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (stop_go),
        .cmd_o (stop_cmd),
        .done_o(stop_done)
    );

    assign line_cmd = top_cmd | stop_cmd;

    i2c_wire_probe_lines #(
        .NBUS       (NBUS_MAX),
        .SYNC_STAGES(SYNC_STAGES),
        .SEL_W      (SEL_W)
    ) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .release_all_i(release_all),
        .sel_i        (pr_q.bus),
        .cmd_i        (line_cmd),
        .scl_in_i     (scl_in_i),
        .sda_in_i     (sda_in_i),
        .scl_low_o    (scl_low_o),
        .sda_low_o    (sda_low_o),
        .scl_seen_o   (scl_seen),
        .sda_seen_o   (sda_seen)
    );

    always_comb begin
        pr_d        = pr_q;
        pr_d.done   = 1'b0;
        top_cmd     = '0;
        release_all = 1'b0;
        tmr_load    = 1'b0;
        tmr_units   = '0;
        stop_go     = 1'b0;
        advance     = 1'b0;

        unique case (pr_q.state)
            PS_IDLE: begin
                if (start_i) begin
                    pr_d.present = '0;
                    pr_d.any_ok  = 1'b0;
                    pr_d.bus     = '0;
                    pr_d.last    = three_bus_i ? SEL_W'(NBUS_MAX - 1) : SEL_W'(NBUS_FEW - 1);
                    release_all  = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_units    = W_LEAD;
                    pr_d.state   = PS_LEAD;
                end
            end
            PS_LEAD: begin
                if (tmr_expire) begin
                    stop_go    = 1'b1;
                    pr_d.state = PS_STOP_PRE;
                end
            end
            PS_STOP_PRE: begin
                if (stop_done) begin
                    tmr_load   = 1'b1;
                    tmr_units  = W_GAP;
                    pr_d.state = PS_GAP;
                end
            end
            PS_GAP: begin
                if (tmr_expire) begin
                    top_cmd.scl_set = 1'b1;
                    top_cmd.scl_low = 1'b1;
                    tmr_load        = 1'b1;
                    tmr_units       = W_STEP;
                    pr_d.state      = PS_P1_LOW;
                end
            end
            PS_P1_LOW: begin
                if (tmr_expire) begin
                    top_cmd.sda_set = 1'b1;
                    top_cmd.sda_low = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_units       = W_STEP;
                    pr_d.state      = PS_P1_REL;
                end
            end
            PS_P1_REL: begin
                if (tmr_expire) begin
                    if (!scl_seen && sda_seen) begin
                        tmr_load   = 1'b1;
                        tmr_units  = W_STEP;
                        pr_d.state = PS_P2_WAIT;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            PS_P2_WAIT: begin
                if (tmr_expire) begin
                    top_cmd.scl_set = 1'b1;
                    top_cmd.scl_low = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_units       = W_STEP;
                    pr_d.state      = PS_P2_REL;
                end
            end
            PS_P2_REL: begin
                if (tmr_expire) begin
                    top_cmd.sda_set = 1'b1;
                    top_cmd.sda_low = 1'b1;
                    tmr_load        = 1'b1;
                    tmr_units       = W_STEP;
                    pr_d.state      = PS_P2_LOW;
                end
            end
            PS_P2_LOW: begin
                if (tmr_expire) begin
                    if (scl_seen && !sda_seen) begin
                        pr_d.present[pr_q.bus] = 1'b1;
                        tmr_load               = 1'b1;
                        tmr_units              = W_STEP;
                        pr_d.state             = PS_TAIL;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            PS_TAIL: begin
                if (tmr_expire) begin
                    stop_go    = 1'b1;
                    pr_d.state = PS_STOP_POST;
                end
            end
            PS_STOP_POST: begin
                if (stop_done) begin
                    advance = 1'b1;
                end
            end
            default: pr_d.state = PS_IDLE;
        endcase

        if (advance) begin
            if (pr_q.bus == pr_q.last) begin
                pr_d.done   = 1'b1;
                pr_d.any_ok = |pr_d.present;
                pr_d.state  = PS_IDLE;
            end else begin
                pr_d.bus   = pr_q.bus + SEL_W'(1);
                tmr_load   = 1'b1;
                tmr_units  = W_LEAD;
                pr_d.state = PS_LEAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q.state   <= PS_IDLE;
            pr_q.bus     <= '0;
            pr_q.last    <= '0;
            pr_q.present <= '0;
            pr_q.any_ok  <= 1'b0;
            pr_q.done    <= 1'b0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign idle_w    = (pr_q.state == PS_IDLE);
    assign present_o = pr_q.present;
    assign any_ok_o  = pr_q.any_ok;
    assign done_o    = pr_q.done;

endmodule

// File: rtl/i2c_wire_probe_chk.sv
module i2c_wire_probe_chk #(
    parameter int unsigned NBUS_MAX = 3,
    parameter int unsigned NBUS_FEW = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                three_bus_i,
    input logic                idle_i,
    input logic [NBUS_MAX-1:0] scl_low_i,
    input logic [NBUS_MAX-1:0] sda_low_i,
    input logic [NBUS_MAX-1:0] present_i,
    input logic                any_ok_i,
    input logic                done_i
);

    localparam logic [NBUS_MAX-1:0] SPARE_MASK = ~(NBUS_MAX'((1 << NBUS_FEW) - 1));

    logic cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= 1'b0;
        end else if (start_i && idle_i) begin
            cfg_q <= three_bus_i;
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle_i) |=> (present_i == '0 && !any_ok_i && scl_low_i == '0 && sda_low_i == '0)); // R1

    AST_SPARE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !cfg_q) |-> (((present_i | scl_low_i | sda_low_i) & SPARE_MASK) == '0)); // R2

    AST_PRESENT_IDLED: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> ((present_i & (scl_low_i | sda_low_i)) == '0)); // R6

    AST_ANY_OK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (any_ok_i == (present_i != '0))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i); // R9

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && !start_i && !done_i) |=> $stable(present_i)); // R8

endmodule

bind i2c_wire_probe i2c_wire_probe_chk #(
    .NBUS_MAX(NBUS_MAX),
    .NBUS_FEW(NBUS_FEW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .three_bus_i(three_bus_i),
    .idle_i     (idle_w),
    .scl_low_i  (scl_low_o),
    .sda_low_i  (sda_low_o),
    .present_i  (present_o),
    .any_ok_i   (any_ok_o),
    .done_i     (done_o)
);

// File: tb/tb_i2c_wire_probe.sv
module tb_i2c_wire_probe;

    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 2;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       three_bus_i = 1'b0;
    logic [2:0] scl_in_i;
    logic [2:0] sda_in_i;
    logic [2:0] scl_low_o;
    logic [2:0] sda_low_o;
    logic [2:0] present_o;
    logic       any_ok_o;
    logic       done_o;

    logic [1:0] fault [3];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_wire_probe #(
        .NBUS_MAX   (3),
        .NBUS_FEW   (2),
        .UNIT_CYCLES(UNIT),
        .SYNC_STAGES(2)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .three_bus_i(three_bus_i),
        .scl_in_i   (scl_in_i),
        .sda_in_i   (sda_in_i),
        .scl_low_o  (scl_low_o),
        .sda_low_o  (sda_low_o),
        .present_o  (present_o),
        .any_ok_o   (any_ok_o),
        .done_o     (done_o)
    );

    // fault model: 0 good, 1 clock stuck low, 2 data stuck high, 3 lines crossed
    // returns {clock level, data level}
    function automatic logic [1:0] line_model(input logic [1:0] m, input logic sl, input logic dl);
        case (m)
            2'd0:    return {~sl, ~dl};
            2'd1:    return {1'b0, ~dl};
            2'd2:    return {~sl, 1'b1};
            default: return {~dl, ~sl};
        endcase
    endfunction

    always_comb begin
        for (int b = 0; b < 3; b++) begin
            {scl_in_i[b], sda_in_i[b]} = line_model(fault[b], scl_low_o[b], sda_low_o[b]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_probe(input logic three, input logic [1:0] m0, input logic [1:0] m1,
                             input logic [1:0] m2, input bit trace);
        logic [1:0] ms [3];
        logic [2:0] e_pres, e_scl, e_sda;
        int         exp_len;
        int         k;
        int         nev;
        int         ev_t [8];
        logic [1:0] ev_v [8];
        logic [1:0] prev;
        int         exp_t [6];
        logic [1:0] exp_v [6];

        ms = '{m0, m1, m2};
        e_pres = '0; e_scl = '0; e_sda = '0; exp_len = 0;
        for (int b = 0; b < 3; b++) begin
            bit tested, p1, p2;
            tested = (b < (three ? 3 : 2));
            p1 = (line_model(ms[b], 1'b1, 1'b0) == 2'b01);
            p2 = (line_model(ms[b], 1'b0, 1'b1) == 2'b10);
            if (tested) begin
                e_pres[b] = p1 && p2;
                e_scl[b]  = !p1;
                e_sda[b]  = p1 && !p2;
                exp_len  += !p1 ? 36 : (!p2 ? 45 : 66);
            end
        end

        @(negedge clk);
        fault[0] = m0; fault[1] = m1; fault[2] = m2;
        start_i = 1'b1;
        three_bus_i = three;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        three_bus_i = !three;   // R2: later changes must not matter
        k = 0;
        chk(present_o == 3'b000 && !any_ok_o, "R1 flags cleared", {present_o, any_ok_o}, 0);
        chk(scl_low_o == 3'b000 && sda_low_o == 3'b000, "R1 lines released",
            {scl_low_o, sda_low_o}, 0);

        prev = {scl_low_o[0], sda_low_o[0]};
        nev = 0;
        while (!done_o && k < 4000) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (trace && {scl_low_o[0], sda_low_o[0]} != prev) begin
                if (nev < 8) begin
                    ev_t[nev] = k;
                    ev_v[nev] = {scl_low_o[0], sda_low_o[0]};
                end
                nev++;
                prev = {scl_low_o[0], sda_low_o[0]};
            end
        end

        chk(done_o && k == exp_len * UNIT, "R9 completion cycle", k, exp_len * UNIT);
        chk(present_o == e_pres, "R6 present flags", present_o, e_pres);
        chk(scl_low_o == e_scl, "R7 residual clock drive", scl_low_o, e_scl);
        chk(sda_low_o == e_sda, "R7 residual data drive", sda_low_o, e_sda);
        chk(any_ok_o == (e_pres != 0), "R8 any_ok", any_ok_o, e_pres != 0);
        if (!three) begin
            chk(!present_o[2] && !scl_low_o[2] && !sda_low_o[2], "R2 spare bus untouched",
                {present_o[2], scl_low_o[2], sda_low_o[2]}, 0);
        end

        @(negedge clk);
        chk(!done_o, "R9 done single cycle", done_o, 0);
        chk(present_o == e_pres && any_ok_o == (e_pres != 0), "R8 result held",
            {present_o, any_ok_o}, {e_pres, e_pres != 0});

        if (trace) begin
            exp_t = '{6, 18, 30, 39, 42, 60};
            exp_v = '{2'b01, 2'b00, 2'b10, 2'b00, 2'b01, 2'b00};
            chk(nev == 6, "R3 bus0 drive change count", nev, 6);
            for (int i = 0; i < 6 && i < nev; i++) begin
                string tag;
                tag = (i < 2) ? "R3 STOP step" : (i < 3) ? "R4 pattern one step" :
                      (i < 5) ? "R5 pattern two step" : "R6 closing STOP step";
                chk(ev_t[i] == exp_t[i] * UNIT, {tag, " time"}, ev_t[i], exp_t[i] * UNIT);
                chk(ev_v[i] == exp_v[i], {tag, " value"}, ev_v[i], exp_v[i]);
            end
        end
    endtask

    initial begin
        fault = '{2'd0, 2'd0, 2'd0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(present_o == 3'b000 && !any_ok_o && !done_o, "R1 reset state",
            {present_o, any_ok_o, done_o}, 0);
        chk(scl_low_o == 3'b000 && sda_low_o == 3'b000, "R1 reset lines",
            {scl_low_o, sda_low_o}, 0);

        // schedule trace on healthy buses (R3 R4 R5 R6)
        run_probe(1'b0, 2'd0, 2'd0, 2'd0, 1'b1);

        // sweep every fault combination under both bus counts (R2 R4 R5 R7 R8 R9)
        for (int t = 0; t < 2; t++) begin
            for (int c = 0; c < 64; c++) begin
                logic [5:0] cv;
                cv = 6'(c);
                run_probe(t[0], cv[1:0], cv[3:2], cv[5:4], 1'b0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule